// File: doc/BRIEF.md
# Address-Derived Test Data Generator and Checker

This unit turns a transfer address into a 64-bit test word, so the data for any location can be rebuilt at any time without a data memory. A small index field is taken from the address. One of five pattern families is then applied to it: a single travelling one, a single travelling zero, alternating all-ones and all-zeros words, a plain counter, and a one-to-one scrambled value. The generated word is combinational, so an outgoing burst gets one word per data phase with no added latency.

For incoming traffic the same word serves as the expected value. When a beat is strobed in receive mode, the received word is compared with the expected word in the enabled byte lanes only. The first mismatch sets a sticky error flag and records the failing address, the expected word and the received word. A clear input releases the flag. Any burst starting at any offset can be checked as it arrives.

Top module: `addr_pattern_gen`

## Requirements
- R1: With pattern code 0, `gen_data` has exactly one set bit, at position `idx mod 64`, where `idx = addr[22:2]` (21 bits; other address bits have no effect on any pattern).
- R2: With pattern code 1, `gen_data` is the bitwise inverse of the code-0 word for the same address (one cleared bit at `idx mod 64`).
- R3: With pattern code 2, `gen_data` is all ones when `idx` is even and all zeros when `idx` is odd.
- R4: With pattern code 3, `gen_data` equals `idx` zero-extended to 64 bits.
- R5: With pattern code 4, let `y = x ^ (x << 7)`, `z = y ^ (y >> 5)` and `w = z * 21'h0B5A63`, all kept to 21 bits with `x = idx`. Then `gen_data = {~w[0], w, ~w, w}`, which is one-to-one over all 2^21 index values.
- R6: `gen_data` follows `pat_sel` and `addr` in the same cycle with no register on the path. Pattern codes 5, 6 and 7 give an all-zeros word.
- R7: When `strobe` and `rx_mode` are high at a clock edge, bits `8k+7:8k` take part in the comparison only if `byte_en[k]` is 1. A difference in a compared bit sets `err_flag` at that edge. A difference in masked bytes does not set it.
- R8: The first mismatch that sets `err_flag` loads `err_addr`, `err_exp` and `err_rcv` with that beat's address, expected word and received word. These registers and the flag then hold through later mismatches until cleared.
- R9: `clr_err` high at an edge leaves `err_flag` low after that edge, even when a mismatching beat is strobed in the same cycle.
- R10: A beat with `strobe` low, or with `rx_mode` low (transmit), never sets `err_flag`, whatever `rx_data` holds.
- R11: After reset `err_flag` is 0 and `err_addr`, `err_exp` and `err_rcv` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_sel | input | 3 | Pattern code (0 walk-one, 1 walk-zero, 2 bounce, 3 count, 4 scrambled) |
| addr | input | 64 | Address of the current data phase |
| strobe | input | 1 | Data phase valid |
| rx_mode | input | 1 | 1: compare incoming data, 0: outgoing generation only |
| rx_data | input | 64 | Received data word |
| byte_en | input | 8 | Byte lanes taking part in the compare |
| clr_err | input | 1 | Clears the error flag |
| gen_data | output | 64 | Generated/expected word for `addr` |
| err_flag | output | 1 | Sticky mismatch flag |
| err_addr | output | 64 | Address of the first failing beat |
| err_exp | output | 64 | Expected word of the first failing beat |
| err_rcv | output | 64 | Received word of the first failing beat |

## Verification
The bench builds the unit with its default widths: a 21-bit index from address bit 2, with 64-bit data and address. With these widths, all eight pattern codes can be swept over the lowest 4096 index values. Every walking-bit position, both bounce phases and the counter's low carries are reached this way, and index values at the top of the 21-bit range are checked as well. The upper address bits are set to varying junk during the sweep to show that they have no effect. The compare path is driven beat by beat, covering clean data, a mismatch in a masked lane, the first capture, a second mismatch that must not overwrite it, and a clear that arrives together with a mismatch.

// File: rtl/addr_pattern_gen.sv
module addr_pattern_gen #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 21,
  parameter logic [IDX_W-1:0] MIX_K = 21'h0B5A63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pat_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              rx_mode,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W/8-1:0] byte_en,
  input  logic              clr_err,
  output logic [DATA_W-1:0] gen_data,
  output logic              err_flag,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_exp,
  output logic [DATA_W-1:0] err_rcv
);
  localparam int NBYTES = DATA_W / 8;
  localparam int WB     = $clog2(DATA_W);

  logic [IDX_W-1:0]  idx, mix_y, mix_z, mix_w;
  logic [DATA_W-1:0] walk, scram, lane_mask;
  logic              beat_bad;

  assign idx   = addr[IDX_LO +: IDX_W];
  assign walk  = {{(DATA_W-1){1'b0}}, 1'b1} << idx[WB-1:0];
  assign mix_y = idx ^ (idx << 7);
  assign mix_z = mix_y ^ (mix_y >> 5);
  assign mix_w = mix_z * MIX_K;

  always_comb begin
    for (int j = 0; j < DATA_W; j++)
      scram[j] = mix_w[j % IDX_W] ^ (((j / IDX_W) % 2) == 1);
    for (int k = 0; k < NBYTES; k++)
      lane_mask[8*k +: 8] = {8{byte_en[k]}};
  end

  always_comb begin
    case (pat_sel)
      3'd0:    gen_data = walk;
      3'd1:    gen_data = ~walk;
      3'd2:    gen_data = idx[0] ? '0 : '1;
      3'd3:    gen_data = DATA_W'(idx);
      3'd4:    gen_data = scram;
      default: gen_data = '0;
    endcase
  end

  assign beat_bad = strobe && rx_mode && (((rx_data ^ gen_data) & lane_mask) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
      err_exp  <= '0;
      err_rcv  <= '0;
    end else if (clr_err) begin
      err_flag <= 1'b0;
    end else if (beat_bad && !err_flag) begin
      err_flag <= 1'b1;
      err_addr <= addr;
      err_exp  <= gen_data;
      err_rcv  <= rx_data;
    end
  end

  a_r1_walk_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == 3'd0) |-> ($countones(gen_data) == 1));

  a_r2_walk_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == 3'd1) |-> ($countones(~gen_data) == 1));

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !clr_err && strobe && rx_mode &&
     (((rx_data ^ gen_data) & lane_mask) != '0))
    |=> (err_flag && err_addr == $past(addr) && err_exp == $past(gen_data)
         && err_rcv == $past(rx_data)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> (err_flag && $stable(err_addr) && $stable(err_exp)
                                && $stable(err_rcv)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !err_flag);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && (!strobe || !rx_mode)) |=> !err_flag);
endmodule

// File: tb/addr_pattern_gen_tb.sv
`timescale 1ns/1ps
module addr_pattern_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pat_sel = '0;
  logic [63:0] addr = '0;
  logic        strobe = 1'b0;
  logic        rx_mode = 1'b0;
  logic [63:0] rx_data = '0;
  logic [7:0]  byte_en = '0;
  logic        clr_err = 1'b0;
  logic [63:0] gen_data, err_addr, err_exp, err_rcv;
  logic        err_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .addr(addr), .strobe(strobe),
    .rx_mode(rx_mode), .rx_data(rx_data), .byte_en(byte_en), .clr_err(clr_err),
    .gen_data(gen_data), .err_flag(err_flag), .err_addr(err_addr),
    .err_exp(err_exp), .err_rcv(err_rcv));

  function automatic logic [63:0] model(input int p, input logic [63:0] a);
    logic [20:0] x, y, z, w;
    x = a[22:2];
    y = x ^ {x[13:0], 7'b0};
    z = y ^ {5'b0, y[20:5]};
    w = z * 21'h0B5A63;
    case (p)
      0: model = 64'd1 << (x % 64);
      1: model = ~(64'd1 << (x % 64));
      2: model = (x % 2 == 0) ? {64{1'b1}} : 64'd0;
      3: model = {43'd0, x};
      4: model = {~w[0], w, ~w, w};
      default: model = 64'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [63:0] a, input logic [63:0] d, input logic [7:0] be,
                      input logic st, input logic rx, input logic clr);
    @(negedge clk);
    pat_sel = 3'd4; addr = a; rx_data = d; byte_en = be;
    strobe = st; rx_mode = rx; clr_err = clr;
    @(posedge clk);
    #1;
    strobe = 1'b0; clr_err = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] a1, a2, e1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 flag", {63'd0, err_flag}, 64'd0);
    chk("R11 addr", err_addr, 64'd0);
    chk("R11 exp", err_exp, 64'd0);
    chk("R11 rcv", err_rcv, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 sweep; R10 junk rx_data with transmit/idle beats
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 4100; i++) begin
        logic [20:0] ix;
        ix = (i < 4096) ? 21'(i) : (i == 4096 ? 21'h1FFFFF : (i == 4097 ? 21'h100000 :
              (i == 4098 ? 21'h0AAAAA : 21'h155555)));
        pat_sel = 3'(p);
        addr = {41'(i * 977) ^ 41'h1A5A5A5A5A, ix, 2'(i)};
        rx_data = ~model(p, addr);
        byte_en = 8'hFF;
        strobe = i[0];
        rx_mode = 1'b0;
        #1;
        chk($sformatf("R%0d pattern %0d idx %0h", (p < 5) ? p + 1 : 6, p, ix),
            gen_data, model(p, addr));
      end
    end
    strobe = 1'b0;
    @(posedge clk); #1;
    chk("R10 no flag after transmit beats", {63'd0, err_flag}, 64'd0);

    a1 = 64'h0000_1234_0007_FF3C;
    a2 = 64'h0000_0000_0055_0010;
    e1 = model(4, a1);
    beat(a1, e1, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R7 clean beat no flag", {63'd0, err_flag}, 64'd0);
    beat(a1, e1 ^ 64'h0000_0000_FF00_0000, 8'hF7, 1'b1, 1'b1, 1'b0);
    chk("R7 masked lane no flag", {63'd0, err_flag}, 64'd0);
    beat(a1, e1 ^ 64'h0000_0000_0100_0000, 8'hFF, 1'b0, 1'b1, 1'b0);
    chk("R10 unstrobed no flag", {63'd0, err_flag}, 64'd0);
    beat(a1, e1 ^ 64'h0000_0000_0100_0000, 8'h08, 1'b1, 1'b1, 1'b0);
    chk("R7 enabled lane sets flag", {63'd0, err_flag}, 64'd1);
    chk("R8 err_addr", err_addr, a1);
    chk("R8 err_exp", err_exp, e1);
    chk("R8 err_rcv", err_rcv, e1 ^ 64'h0000_0000_0100_0000);
    beat(a2, 64'd0, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R8 second mismatch keeps addr", err_addr, a1);
    chk("R8 second mismatch keeps rcv", err_rcv, e1 ^ 64'h0000_0000_0100_0000);
    chk("R8 flag sticky", {63'd0, err_flag}, 64'd1);
    beat(a2, 64'd0, 8'hFF, 1'b0, 1'b0, 1'b1);
    chk("R9 clear", {63'd0, err_flag}, 64'd0);
    beat(a2, 64'd0, 8'hFF, 1'b1, 1'b1, 1'b1);
    chk("R9 clear beats capture", {63'd0, err_flag}, 64'd0);
    beat(a2, 64'd0, 8'h01, 1'b1, 1'b1, 1'b0);
    chk("R8 recapture flag", {63'd0, err_flag}, 64'd1);
    chk("R8 recapture addr", err_addr, a2);
    chk("R8 recapture exp", err_exp, model(4, a2));
    chk("R8 recapture rcv", err_rcv, 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule